// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block holds the command and status register that a nonvolatile memory controller uses to launch program and erase operations. Software writes an operation code, arms a separate enable bit and then sets a start bit. The start bit takes effect only when an external key sequencer reports that the unlock sequence has been satisfied and a temperature-override enable is high. On a valid start the controller resolves the code into the operation the flash engine should actually run. It sends that operation to the engine as a one-cycle start pulse and holds the start bit high until the engine reports done.

Several codes are rewritten or dropped during resolution. The two region-erase codes are aliases of the full program-memory erase because the array has a single bank. Chip erase is honoured only for debug-path accesses. Word program is dropped in one ECC mode and runs without ECC in the others. Reserved codes do nothing. A dropped or reserved command still shows the start bit high for one cycle. Three sticky status flags are kept: an engine failure flag, and low-voltage and high-temperature flags sampled during a running operation. All three are cleared by launching the no-operation code.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the register reads 0. The layout is start at bit 15, enable at bit 14, write-error at bit 13, low-voltage error at bit 12, high-temperature at bit 8 and the operation code at bits 3:0. All other bits read 0.
- R2: A register write with bit 15 set launches a command only if the enable bit already reads 1, unlock_ok_i is 1, temp_ovr_en_i is 1 and the start bit reads 0. Otherwise the start request is ignored: the start bit stays 0 and no engine start is issued.
- R3: The operation code field (bits 3:0) takes the written value only when the enable bit read 0 before the write. The enable bit itself is written on every register write.
- R4: A launched executable command raises eng_start_o for exactly one cycle, in the cycle after the write, with eng_op_o set to the resolved code. The start bit reads 1 from that cycle until the clock edge at which eng_done_i is 1, after which it reads 0.
- R5: Codes 0101 and 0110 are issued to the engine as 0111 (full program-memory erase). Codes 0010, 0011, 0100 and 0111 are issued unchanged.
- R6: Code 1110 (chip erase) is issued only when dbg_access_i is 1 at launch. Otherwise it is suppressed.
- R7: Code 0001 (word program) is suppressed when ecc_mode_i is 00. For any other ECC mode it is issued with eng_skip_ecc_o high during the start pulse. eng_skip_ecc_o is 0 for every other code.
- R8: Code 0000, the suppressed commands and the reserved codes (1000 to 1101 and 1111) issue no engine start. The start bit reads 1 for exactly one cycle after the write.
- R9: eng_fail_i high together with eng_done_i, during a running operation, sets the write-error bit. Done without fail leaves it unchanged.
- R10: lvd_i and htd_i set the low-voltage bit and the high-temperature bit only while an issued operation is running. While idle, both inputs are ignored.
- R11: Launching code 0000 clears the write-error, low-voltage and high-temperature bits. Launching any other code keeps them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| unlock_ok_i | input | 1 | Unlock sequence satisfied (from key sequencer) |
| temp_ovr_en_i | input | 1 | Temperature-override enable |
| dbg_access_i | input | 1 | Access arrives through the debug path |
| ecc_mode_i | input | 2 | Dynamic ECC mode |
| lvd_i | input | 1 | Low-voltage detector |
| htd_i | input | 1 | High-temperature detector |
| eng_start_o | output | 1 | One-cycle start pulse to flash engine |
| eng_op_o | output | 4 | Resolved operation code |
| eng_skip_ecc_o | output | 1 | Engine must not write ECC bits |
| eng_done_i | input | 1 | Engine operation complete |
| eng_fail_i | input | 1 | Engine operation failed (valid with done) |

## Verification
Completion and detector capture can fall in the same cycle. The edge that ends an operation on eng_done_i still sees the start bit high, so a detector pulse in that cycle must be latched. A failure flag and a detector flag can likewise rise on the same edge. The bench raises lvd_i and htd_i during a running page erase, then raises done together with a fail indication, and expects the write-error and detector bits all set while the start bit drops. It then checks that a later non-zero launch keeps those bits and that only a no-operation launch clears them.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int OP_W = 4;

  localparam int BIT_START = 15;
  localparam int BIT_EN    = 14;
  localparam int BIT_WERR  = 13;
  localparam int BIT_LVERR = 12;
  localparam int BIT_HTEMP = 8;

  localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
  localparam logic [OP_W-1:0] OP_WORD  = 4'h1;
  localparam logic [OP_W-1:0] OP_QUAD  = 4'h2;
  localparam logic [OP_W-1:0] OP_ROW   = 4'h3;
  localparam logic [OP_W-1:0] OP_PAGE  = 4'h4;
  localparam logic [OP_W-1:0] OP_LOWER = 4'h5;
  localparam logic [OP_W-1:0] OP_UPPER = 4'h6;
  localparam logic [OP_W-1:0] OP_ALL   = 4'h7;
  localparam logic [OP_W-1:0] OP_CHIP  = 4'hE;

  localparam logic [1:0] ECC_ALWAYS = 2'b00;

  typedef struct packed {
    logic            exec;
    logic            skip_ecc;
    logic [OP_W-1:0] op;
  } resolved_t;
endpackage

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate (
  input  logic reg_we_i,
  input  logic start_req_i,
  input  logic en_q_i,
  input  logic busy_i,
  input  logic unlock_ok_i,
  input  logic temp_ovr_en_i,
  output logic launch_o,
  output logic op_we_o
);
  // start needs enable armed by an earlier write
  assign launch_o = reg_we_i & start_req_i & en_q_i & unlock_ok_i &
                    temp_ovr_en_i & ~busy_i;
  assign op_we_o  = reg_we_i & ~en_q_i;
endmodule

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_cmd_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [1:0]      ecc_mode_i,
  input  logic            dbg_access_i,
  output resolved_t       res_o
);
  always_comb begin
    res_o = '{exec: 1'b0, skip_ecc: 1'b0, op: op_i};
    unique case (op_i)
      OP_WORD: begin
        res_o.exec     = (ecc_mode_i != ECC_ALWAYS);
        res_o.skip_ecc = (ecc_mode_i != ECC_ALWAYS);
      end
      OP_QUAD, OP_ROW, OP_PAGE, OP_ALL: res_o.exec = 1'b1;
      OP_LOWER, OP_UPPER: begin
        res_o.exec = 1'b1;
        res_o.op   = OP_ALL;  // single bank
      end
      OP_CHIP: res_o.exec = dbg_access_i;
      default: res_o.exec = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_err_capture.sv
module flash_err_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic done_i,
  input  logic fail_i,
  input  logic lvd_i,
  input  logic htd_i,
  output logic werr_o,
  output logic lverr_o,
  output logic htemp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      werr_o  <= 1'b0;
      lverr_o <= 1'b0;
      htemp_o <= 1'b0;
    end else if (clear_i) begin
      werr_o  <= 1'b0;
      lverr_o <= 1'b0;
      htemp_o <= 1'b0;
    end else if (run_i) begin
      if (done_i && fail_i) werr_o <= 1'b1;
      if (lvd_i) lverr_o <= 1'b1;
      if (htd_i) htemp_o <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              unlock_ok_i,
  input  logic              temp_ovr_en_i,
  input  logic              dbg_access_i,
  input  logic [1:0]        ecc_mode_i,
  input  logic              lvd_i,
  input  logic              htd_i,
  output logic              eng_start_o,
  output logic [OP_W-1:0]   eng_op_o,
  output logic              eng_skip_ecc_o,
  input  logic              eng_done_i,
  input  logic              eng_fail_i
);
  logic            start_q, active_q, en_q;
  logic [OP_W-1:0] op_q;
  logic            launch, op_we;
  resolved_t       res;
  logic            werr, lverr, htemp;
  logic            unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[DATA_W-1:BIT_START+1],
                          reg_wdata_i[BIT_EN-1:OP_W]};

  flash_cmd_gate u_gate (
    .reg_we_i      (reg_we_i),
    .start_req_i   (reg_wdata_i[BIT_START]),
    .en_q_i        (en_q),
    .busy_i        (start_q),
    .unlock_ok_i   (unlock_ok_i),
    .temp_ovr_en_i (temp_ovr_en_i),
    .launch_o      (launch),
    .op_we_o       (op_we)
  );

  flash_op_decode u_dec (
    .op_i         (op_q),
    .ecc_mode_i   (ecc_mode_i),
    .dbg_access_i (dbg_access_i),
    .res_o        (res)
  );

  flash_err_capture u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch && (op_q == OP_NOP)),
    .run_i   (start_q && active_q),
    .done_i  (eng_done_i),
    .fail_i  (eng_fail_i),
    .lvd_i   (lvd_i),
    .htd_i   (htd_i),
    .werr_o  (werr),
    .lverr_o (lverr),
    .htemp_o (htemp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      op_q <= '0;
    end else begin
      if (reg_we_i) en_q <= reg_wdata_i[BIT_EN];
      if (op_we)    op_q <= reg_wdata_i[OP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q        <= 1'b0;
      active_q       <= 1'b0;
      eng_start_o    <= 1'b0;
      eng_op_o       <= '0;
      eng_skip_ecc_o <= 1'b0;
    end else if (launch) begin
      start_q        <= 1'b1;
      active_q       <= res.exec;
      eng_start_o    <= res.exec;
      eng_op_o       <= res.op;
      eng_skip_ecc_o <= res.exec & res.skip_ecc;
    end else begin
      eng_start_o    <= 1'b0;
      eng_skip_ecc_o <= 1'b0;
      // suppressed commands drop after one cycle
      if (start_q && (!active_q || eng_done_i)) begin
        start_q  <= 1'b0;
        active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[BIT_START] = start_q;
    reg_rdata_o[BIT_EN]    = en_q;
    reg_rdata_o[BIT_WERR]  = werr;
    reg_rdata_o[BIT_LVERR] = lverr;
    reg_rdata_o[BIT_HTEMP] = htemp;
    reg_rdata_o[OP_W-1:0]  = op_q;
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              unlock_ok_i,
  input logic              temp_ovr_en_i,
  input logic              dbg_access_i,
  input logic              eng_start_o,
  input logic [OP_W-1:0]   eng_op_o,
  input logic              eng_skip_ecc_o,
  input logic              eng_done_i,
  input logic              eng_fail_i,
  input logic              active_q
);
  p_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_done_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[BIT_START] && eng_done_i) |=> !reg_rdata_o[BIT_START]);

  p_start_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[BIT_START]) |->
      $past(reg_we_i && reg_wdata_i[BIT_START] && unlock_ok_i && temp_ovr_en_i
            && reg_rdata_o[BIT_EN]));

  p_no_region_op_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (eng_op_o != OP_LOWER && eng_op_o != OP_UPPER));

  p_chip_dbg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && eng_op_o == OP_CHIP) |-> $past(dbg_access_i));

  p_skip_ecc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_skip_ecc_o |-> (eng_start_o && eng_op_o == OP_WORD));

  p_fail_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[BIT_START] && active_q && eng_done_i && eng_fail_i)
      |=> reg_rdata_o[BIT_WERR]);

  p_start_reads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> reg_rdata_o[BIT_START]);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .unlock_ok_i    (unlock_ok_i),
  .temp_ovr_en_i  (temp_ovr_en_i),
  .dbg_access_i   (dbg_access_i),
  .eng_start_o    (eng_start_o),
  .eng_op_o       (eng_op_o),
  .eng_skip_ecc_o (eng_skip_ecc_o),
  .eng_done_i     (eng_done_i),
  .eng_fail_i     (eng_fail_i),
  .active_q       (active_q)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        unlock = 1'b1, temp = 1'b1, dbg = 1'b0;
  logic [1:0]  ecc = 2'b01;
  logic        lvd = 1'b0, htd = 1'b0;
  logic        st, skip, done = 1'b0, fail = 1'b0;
  logic [3:0]  eop;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .unlock_ok_i (unlock), .temp_ovr_en_i (temp),
    .dbg_access_i (dbg), .ecc_mode_i (ecc), .lvd_i (lvd), .htd_i (htd),
    .eng_start_o (st), .eng_op_o (eop), .eng_skip_ecc_o (skip),
    .eng_done_i (done), .eng_fail_i (fail)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  // clear enable, load code, arm enable, request start; ends sampling the pulse cycle
  task automatic launch(input logic [3:0] op);
    wr(32'h0);
    wr({28'h0, op});
    wr({16'h0, 16'h4000 | {12'h0, op}});
    wr({16'h0, 16'hC000 | {12'h0, op}});
  endtask

  task automatic finish_op(input logic f);
    @(negedge clk); done = 1'b1; fail = f;
    @(negedge clk); done = 1'b0; fail = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset start", {31'h0, st}, 32'h0);
  endtask

  task automatic t_gate;
    wr(32'h0000_8000);
    chk("R2 start without enable", rdata, 32'h0);
    chk("R2 no engine start", {31'h0, st}, 32'h0);
    wr(32'h0000_4000);
    unlock = 1'b0;
    wr(32'h0000_C000);
    chk("R2 start without unlock", rdata, 32'h0000_4000);
    unlock = 1'b1; temp = 1'b0;
    wr(32'h0000_C000);
    chk("R2 start without temp enable", rdata, 32'h0000_4000);
    temp = 1'b1; unlock = 1'b0;
    wr(32'hFFFF_7FFF);
    chk("R1 unused bits read zero", rdata, 32'h0000_4000);
    unlock = 1'b1;
  endtask

  task automatic t_opgate;
    wr(32'h0000_4003);
    chk("R3 code blocked while enabled", rdata, 32'h0000_4000);
    wr(32'h0000_0003);
    chk("R3 code blocked, enable drops", rdata, 32'h0000_0000);
    wr(32'h0000_0003);
    chk("R3 code written while disabled", rdata, 32'h0000_0003);
    wr(32'h0);
  endtask

  task automatic t_page;
    launch(4'h4);
    chk("R4 start pulse", {31'h0, st}, 32'h1);
    chk("R4 engine code", {28'h0, eop}, 32'h4);
    chk("R4 start bit set", {31'h0, rdata[15]}, 32'h1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'h0, st}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R4 busy until done", {31'h0, rdata[15]}, 32'h1);
    wr(32'h0000_C000);
    chk("R2 start ignored while busy", {31'h0, st}, 32'h0);
    finish_op(1'b0);
    chk("R4 done clears start", {31'h0, rdata[15]}, 32'h0);
    chk("R9 no fail keeps werr clear", {31'h0, rdata[13]}, 32'h0);
  endtask

  task automatic t_alias;
    for (int c = 5; c <= 7; c++) begin
      launch(c[3:0]);
      chk("R5 region erase alias start", {31'h0, st}, 32'h1);
      chk("R5 region erase alias code", {28'h0, eop}, 32'h7);
      finish_op(1'b0);
    end
    launch(4'h3);
    chk("R5 row code unchanged", {28'h0, eop}, 32'h3);
    finish_op(1'b0);
  endtask

  task automatic t_chip;
    dbg = 1'b0;
    launch(4'hE);
    chk("R6 chip erase without debug", {31'h0, st}, 32'h0);
    chk("R8 suppressed start bit set", {31'h0, rdata[15]}, 32'h1);
    @(negedge clk);
    chk("R8 suppressed start bit drops", {31'h0, rdata[15]}, 32'h0);
    dbg = 1'b1;
    launch(4'hE);
    chk("R6 chip erase via debug", {27'h0, st, eop}, 32'h1E);
    finish_op(1'b0);
    dbg = 1'b0;
  endtask

  task automatic t_word;
    ecc = 2'b00;
    launch(4'h1);
    chk("R7 word program dropped ecc 00", {31'h0, st}, 32'h0);
    @(negedge clk);
    ecc = 2'b01;
    launch(4'h1);
    chk("R7 word program runs", {27'h0, st, eop}, 32'h11);
    chk("R7 skip ecc on word", {31'h0, skip}, 32'h1);
    finish_op(1'b0);
    launch(4'h2);
    chk("R7 no skip ecc on quad", {30'h0, st, skip}, 32'h2);
    finish_op(1'b0);
  endtask

  task automatic t_rsvd;
    logic [3:0] codes [3] = '{4'h8, 4'hF, 4'hB};
    foreach (codes[i]) begin
      launch(codes[i]);
      chk("R8 reserved no engine start", {31'h0, st}, 32'h0);
      chk("R8 reserved start bit set", {31'h0, rdata[15]}, 32'h1);
      @(negedge clk);
      chk("R8 reserved start bit one cycle", {31'h0, rdata[15]}, 32'h0);
    end
  endtask

  task automatic t_fail_capture;
    lvd = 1'b1; htd = 1'b1;
    repeat (2) @(negedge clk);
    lvd = 1'b0; htd = 1'b0;
    chk("R10 detectors ignored idle", {19'h0, rdata[13:12], 3'h0, rdata[8], 8'h0}, 32'h0);
    launch(4'h4);
    @(negedge clk); lvd = 1'b1; htd = 1'b1; done = 1'b1; fail = 1'b1;
    @(negedge clk); lvd = 1'b0; htd = 1'b0; done = 1'b0; fail = 1'b0;
    chk("R9 fail sets werr", {31'h0, rdata[13]}, 32'h1);
    chk("R10 detectors captured at done", {30'h0, rdata[12], rdata[8]}, 32'h3);
    chk("R4 start clears with fail", {31'h0, rdata[15]}, 32'h0);
  endtask

  task automatic t_clear;
    launch(4'h2);
    finish_op(1'b0);
    chk("R11 non-nop keeps flags", {29'h0, rdata[13:12], rdata[8]}, 32'h7);
    launch(4'h0);
    chk("R11 nop clears flags", {29'h0, rdata[13:12], rdata[8]}, 32'h0);
    chk("R8 nop no engine start", {31'h0, st}, 32'h0);
    @(negedge clk);
    chk("R8 nop start bit one cycle", {31'h0, rdata[15]}, 32'h0);
  endtask

  initial begin
    fork
      begin
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_opgate();
        t_page();
        t_alias();
        t_chip();
        t_word();
        t_rsvd();
        t_fail_capture();
        t_clear();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule